// File: doc/BRIEF.md
# Processor Status and Trap Entry Unit

This unit keeps the processor status word and the trap base register of an integer core, and performs the register updates that enter a trap. The status word holds the supervisor bit, the previous-supervisor bit, the trap-enable bit, the floating-point-enable bit, a 4-bit interrupt level and the current window pointer. A window-invalid mask is held alongside them. Software reads and writes the status word, the mask and the trap base through plain strobed ports.

A trap is requested by the core with an 8-bit type code. The unit also watches a strobe that marks the issue of a floating-point instruction, and raises the FPU-disabled trap (type 0x04) itself when that strobe fires while floating point is disabled. Other trap codes that the core is expected to use include 0x02 (illegal instruction), 0x03 (privileged instruction), 0x05 and 0x06 (window spill and fill), 0x08 (floating-point exception), 0x2A (divide by zero), 0x10 upward (external interrupts) and 0x80 upward (software traps).

When traps are enabled, a trap changes several fields in one clock edge: the window rotates down by one, the supervisor bit moves into the previous-supervisor bit and is then set, traps are disabled, and the type code is placed in the trap base register. The result forms the vector address. A trap that arrives while traps are already disabled is refused, and the unit enters a sticky error state.

Top module: `psr_trap_unit`

## Requirements
- R1: After reset: supervisor=1, previous supervisor=0, trap enable=0, FP enable=0, level=0, window pointer=0, trap base=0, mask=1 and error state=0, so the status read returns 0x04000080.
- R2: The status read value is built as {4'h0 implementation, 4'h4 version, bits 23:13 zero, FP enable at bit 12, level at 11:8, supervisor at 7, previous supervisor at 6, trap enable at 5, window pointer zero-extended in 4:0}.
- R3: A status write with no trap that cycle loads bits 12, 11:8, 7, 6 and 5, and loads the window pointer from data bits [log2(NWIN)-1:0]. All other written bits are ignored. The new value reads back after the next edge.
- R4: A trap-base write with no trap that cycle loads the 20-bit base into bits 31:12. Bits 11:4 hold the last trap type, and bits 3:0 always read zero.
- R5: A trap with trap enable=1 changes state at the next edge: trap enable=0, window pointer=(old-1) mod NWIN, previous supervisor=old supervisor, supervisor=1, bits 11:4 of the trap base=type, base bits kept. The saved PC outputs take curPc and curPc+4, and trapTaken pulses for that one cycle. trapVector shows the new trap base.
- R6: A trap with trap enable=0 changes no register. errorState rises after the next edge and stays high until reset.
- R7: An FPU issue strobe while FP enable=0 is a trap of type 0x04. While FP enable=1 the strobe has no effect.
- R8: An explicit trap request wins over an FPU-disabled trap in the same cycle. Any trap, taken or refused, discards a status, trap-base or mask write in that same cycle.
- R9: A mask write with no trap that cycle loads wimWrData.
- R10: A trap with window pointer 0 wraps it to NWIN-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psrWrEn | input | 1 | Status word write strobe |
| psrWrData | input | 32 | Status word write value |
| psrRdData | output | 32 | Status word read value |
| tbrWrEn | input | 1 | Trap base write strobe |
| tbrWrBase | input | 20 | New trap base bits 31:12 |
| wimWrEn | input | 1 | Window-invalid mask write strobe |
| wimWrData | input | NWIN | New mask value |
| wimRdData | output | NWIN | Mask read value |
| trapReq | input | 1 | Trap request from the core |
| trapType | input | 8 | Type code of the requested trap |
| fpuIssue | input | 1 | Floating-point instruction issue strobe |
| curPc | input | 32 | PC of the instruction in flight |
| savedPc | output | 32 | PC captured at trap entry |
| savedNextPc | output | 32 | curPc+4 captured at trap entry |
| cwpOut | output | log2(NWIN) | Current window pointer |
| trapVector | output | 32 | Trap base register, the vector address after a trap |
| trapTaken | output | 1 | One-cycle pulse after a trap entry |
| errorState | output | 1 | Sticky: a trap arrived with traps disabled |

## Verification
The collisions of interest are a status or trap-base write in the same cycle as a trap, and an explicit trap request in the same cycle as an FPU-disabled issue. Directed steps assert all of these strobes in one cycle. The expected result is that the written values are dropped and the explicit type code is used. Random stimulus then makes the strobes overlap often, and every cycle is compared with a bench model that applies the same precedence rules.

// File: rtl/psr_trap_pkg.sv
package psr_trap_pkg;
  localparam logic [7:0] TT_FPU_OFF = 8'h04;
  localparam logic [3:0] IMPL_ID    = 4'h0;
  localparam logic [3:0] VERSION_ID = 4'h4;

  typedef struct packed {
    logic       takeTrap;
    logic       refuseTrap;
    logic       loadPsr;
    logic       loadTbr;
    logic       loadWim;
    logic [7:0] code;
  } trapStrobes_t;
endpackage

// File: rtl/psr_trap_ctrl.sv
module psr_trap_ctrl
  import psr_trap_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         trapReq,
  input  logic [7:0]   trapType,
  input  logic         fpuIssue,
  input  logic         psrWrEn,
  input  logic         tbrWrEn,
  input  logic         wimWrEn,
  input  logic         etNow,
  input  logic         efNow,
  output trapStrobes_t strobe
);
  logic fpuOff;
  logic anyTrap;

  always_comb begin
    fpuOff            = fpuIssue & ~efNow;
    anyTrap           = trapReq | fpuOff;
    strobe.code       = trapReq ? trapType : TT_FPU_OFF;
    strobe.takeTrap   = anyTrap & etNow;
    strobe.refuseTrap = anyTrap & ~etNow;
    strobe.loadPsr    = psrWrEn & ~anyTrap;
    strobe.loadTbr    = tbrWrEn & ~anyTrap;
    strobe.loadWim    = wimWrEn & ~anyTrap;
  end

  // R7: FPU issue with FP disabled becomes a type 0x04 trap
  a_r7_fpu_off_code: assert property (@(posedge clk) disable iff (!rst_n)
    (fpuIssue && !efNow && !trapReq) |-> (strobe.code == 8'h04 && (strobe.takeTrap || strobe.refuseTrap)));

  // R8: a trap request suppresses all register writes
  a_r8_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    trapReq |-> !(strobe.loadPsr || strobe.loadTbr || strobe.loadWim));

  // R6: a trap is either entered or refused, never both
  a_r6_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strobe.takeTrap, strobe.refuseTrap}));
endmodule

// File: rtl/psr_trap_dpath.sv
module psr_trap_dpath
  import psr_trap_pkg::*;
#(
  parameter int NWIN = 8,
  localparam int CW  = $clog2(NWIN)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  trapStrobes_t    strobe,
  input  logic [31:0]     psrWrData,
  input  logic [19:0]     tbrWrBase,
  input  logic [NWIN-1:0] wimWrData,
  input  logic [31:0]     curPc,
  output logic [31:0]     psrRdData,
  output logic [31:0]     trapVector,
  output logic [NWIN-1:0] wimRdData,
  output logic [CW-1:0]   cwpOut,
  output logic [31:0]     savedPc,
  output logic [31:0]     savedNextPc,
  output logic            errorState,
  output logic            trapTaken,
  output logic            etNow,
  output logic            efNow
);
  logic          sBit, psBit, etBit, efBit;
  logic [3:0]    pil;
  logic [CW-1:0] cwp;
  logic [19:0]   tbrBase;
  logic [7:0]    tbrType;
  logic [NWIN-1:0] wim;
  logic [4:0]    cwpPad;
  logic          unusedWrBits;

  assign unusedWrBits = ^{psrWrData[31:13], psrWrData[4:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sBit        <= 1'b1;
      psBit       <= 1'b0;
      etBit       <= 1'b0;
      efBit       <= 1'b0;
      pil         <= '0;
      cwp         <= '0;
      tbrBase     <= '0;
      tbrType     <= '0;
      wim         <= NWIN'(1);
      savedPc     <= '0;
      savedNextPc <= '0;
      errorState  <= 1'b0;
      trapTaken   <= 1'b0;
    end else begin
      trapTaken <= strobe.takeTrap;
      if (strobe.takeTrap) begin
        etBit       <= 1'b0;
        cwp         <= cwp - CW'(1);
        psBit       <= sBit;
        sBit        <= 1'b1;
        tbrType     <= strobe.code;
        savedPc     <= curPc;
        savedNextPc <= curPc + 32'd4;
      end else if (strobe.refuseTrap) begin
        errorState <= 1'b1;
      end else begin
        if (strobe.loadPsr) begin
          efBit <= psrWrData[12];
          pil   <= psrWrData[11:8];
          sBit  <= psrWrData[7];
          psBit <= psrWrData[6];
          etBit <= psrWrData[5];
          cwp   <= psrWrData[CW-1:0];
        end
        if (strobe.loadTbr) tbrBase <= tbrWrBase;
        if (strobe.loadWim) wim <= wimWrData;
      end
    end
  end

  always_comb begin
    cwpPad         = '0;
    cwpPad[CW-1:0] = cwp;
  end

  assign psrRdData  = {IMPL_ID, VERSION_ID, 11'b0, efBit, pil, sBit, psBit, etBit, cwpPad};
  assign trapVector = {tbrBase, tbrType, 4'h0};
  assign wimRdData  = wim;
  assign cwpOut     = cwp;
  assign etNow      = etBit;
  assign efNow      = efBit;

  // R5: trap entry disables traps and enters supervisor mode
  a_r5_enter_super: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.takeTrap |=> (!etBit && sBit && psBit == $past(sBit)));

  // R5 / R10: window pointer steps down modulo NWIN
  a_r5_window_down: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.takeTrap |=> cwp == CW'($past(cwp) - CW'(1)));

  // R4: base bits survive a trap
  a_r4_base_kept: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.takeTrap |=> $stable(tbrBase));

  // R6: refused trap leaves state untouched, error is sticky
  a_r6_refuse_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.refuseTrap |=> ($stable(cwp) && $stable(tbrType) && $stable(sBit) && errorState));
  a_r6_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    errorState |=> errorState);
endmodule

// File: rtl/psr_trap_unit.sv
module psr_trap_unit
  import psr_trap_pkg::*;
#(
  parameter int NWIN = 8,
  localparam int CW  = $clog2(NWIN)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            psrWrEn,
  input  logic [31:0]     psrWrData,
  output logic [31:0]     psrRdData,
  input  logic            tbrWrEn,
  input  logic [19:0]     tbrWrBase,
  input  logic            wimWrEn,
  input  logic [NWIN-1:0] wimWrData,
  output logic [NWIN-1:0] wimRdData,
  input  logic            trapReq,
  input  logic [7:0]      trapType,
  input  logic            fpuIssue,
  input  logic [31:0]     curPc,
  output logic [31:0]     savedPc,
  output logic [31:0]     savedNextPc,
  output logic [CW-1:0]   cwpOut,
  output logic [31:0]     trapVector,
  output logic            trapTaken,
  output logic            errorState
);
  trapStrobes_t strobe;
  logic etNow, efNow;

  psr_trap_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .trapReq(trapReq), .trapType(trapType),
    .fpuIssue(fpuIssue), .psrWrEn(psrWrEn), .tbrWrEn(tbrWrEn), .wimWrEn(wimWrEn),
    .etNow(etNow), .efNow(efNow), .strobe(strobe)
  );

  psr_trap_dpath #(.NWIN(NWIN)) u_dpath (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .psrWrData(psrWrData),
    .tbrWrBase(tbrWrBase), .wimWrData(wimWrData), .curPc(curPc),
    .psrRdData(psrRdData), .trapVector(trapVector), .wimRdData(wimRdData),
    .cwpOut(cwpOut), .savedPc(savedPc), .savedNextPc(savedNextPc),
    .errorState(errorState), .trapTaken(trapTaken), .etNow(etNow), .efNow(efNow)
  );
endmodule

// File: tb/test_psr_trap_unit.sv
module test_psr_trap_unit;
  localparam int NW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic psrWrEn = 0, tbrWrEn = 0, wimWrEn = 0, trapReq = 0, fpuIssue = 0;
  logic [31:0] psrWrData = '0, curPc = '0;
  logic [19:0] tbrWrBase = '0;
  logic [NW-1:0] wimWrData = '0;
  logic [7:0] trapType = '0;
  logic [31:0] psrRdData, savedPc, savedNextPc, trapVector;
  logic [NW-1:0] wimRdData;
  logic [2:0] cwpOut;
  logic trapTaken, errorState;

  int checks = 0, errors = 0;

  // bench model
  bit mS = 1, mPs = 0, mEt = 0, mEf = 0, mErr = 0, mTaken = 0;
  logic [3:0] mPil = 0;
  int mCwp = 0;
  logic [19:0] mBase = 0;
  logic [7:0] mTt = 0;
  logic [NW-1:0] mWim = 1;
  logic [31:0] mPc = 0, mNpc = 0;

  always #4 clk = ~clk;

  psr_trap_unit #(.NWIN(NW)) i_psr_trap_unit (
    .clk(clk), .rst_n(rst_n), .psrWrEn(psrWrEn), .psrWrData(psrWrData),
    .psrRdData(psrRdData), .tbrWrEn(tbrWrEn), .tbrWrBase(tbrWrBase),
    .wimWrEn(wimWrEn), .wimWrData(wimWrData), .wimRdData(wimRdData),
    .trapReq(trapReq), .trapType(trapType), .fpuIssue(fpuIssue), .curPc(curPc),
    .savedPc(savedPc), .savedNextPc(savedNextPc), .cwpOut(cwpOut),
    .trapVector(trapVector), .trapTaken(trapTaken), .errorState(errorState)
  );

  function automatic logic [31:0] expPsr();
    return {4'h0, 4'h4, 11'b0, mEf, mPil, mS, mPs, mEt, 5'(mCwp)};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input bit tr, input logic [7:0] tt, input bit fi,
                      input bit pw, input logic [31:0] pd,
                      input bit tw, input logic [19:0] td,
                      input bit ww, input logic [NW-1:0] wd, input logic [31:0] pc);
    bit fpuT, anyT;
    @(negedge clk);
    trapReq = tr; trapType = tt; fpuIssue = fi; psrWrEn = pw; psrWrData = pd;
    tbrWrEn = tw; tbrWrBase = td; wimWrEn = ww; wimWrData = wd; curPc = pc;
    @(posedge clk);
    fpuT = fi && !mEf;
    anyT = tr || fpuT;
    mTaken = 0;
    if (anyT) begin
      if (mEt) begin
        mEt = 0; mCwp = (mCwp + NW - 1) % NW; mPs = mS; mS = 1;
        mTt = tr ? tt : 8'h04; mPc = pc; mNpc = pc + 4; mTaken = 1;
      end else mErr = 1;
    end else begin
      if (pw) begin
        mEf = pd[12]; mPil = pd[11:8]; mS = pd[7]; mPs = pd[6]; mEt = pd[5];
        mCwp = int'(pd[2:0]);
      end
      if (tw) mBase = td;
      if (ww) mWim = wd;
    end
    #1;
    check("R3 status read", psrRdData, expPsr());
    check("R4 trap base", trapVector, {mBase, mTt, 4'h0});
    check("R5 window", 32'(cwpOut), 32'(mCwp));
    check("R5 trapTaken", 32'(trapTaken), 32'(mTaken));
    check("R5 savedPc", savedPc, mPc);
    check("R5 savedNextPc", savedNextPc, mNpc);
    check("R6 errorState", 32'(errorState), 32'(mErr));
    check("R9 mask", 32'(wimRdData), 32'(mWim));
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    // R1: reset values
    check("R1 status after reset", psrRdData, 32'h0400_0080);
    check("R1 mask after reset", 32'(wimRdData), 32'h1);
    check("R1 base after reset", trapVector, 32'h0);
    check("R1 error after reset", 32'(errorState), 32'h0);
    rst_n = 1'b1;
    idle();
    // R2: all writable bits set
    step(0, 0, 0, 1, 32'hFFFF_FFFF, 0, 0, 0, 0, 0);
    check("R2 status layout", psrRdData, 32'h0400_1FE7);
    // R10: trap from window 0 wraps
    step(0, 0, 0, 1, 32'h0000_00A0, 0, 0, 0, 0, 0);
    step(1, 8'h2A, 0, 0, 0, 0, 0, 0, 0, 32'h0000_1000);
    check("R10 window wrap", 32'(cwpOut), 32'd7);
    check("R5 status after trap", psrRdData, 32'h0400_00C7);
    check("R5 vector", trapVector, 32'h0000_02A0);
    check("R5 saved next pc", savedNextPc, 32'h0000_1004);
    // R7: FPU issue with FP disabled
    step(0, 0, 0, 1, 32'h0000_00A3, 0, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0, 0, 0, 0, 0, 32'h0000_2000);
    check("R7 fpu-off vector", trapVector, 32'h0000_0040);
    check("R7 fpu-off window", 32'(cwpOut), 32'd2);
    // R7: FPU issue with FP enabled has no effect
    step(0, 0, 0, 1, 32'h0000_10A3, 0, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0, 0, 0, 0, 0, 32'h0000_3000);
    check("R7 fpu-on no trap", 32'(trapTaken), 32'd0);
    check("R7 fpu-on window kept", 32'(cwpOut), 32'd3);
    // R8: collisions
    step(0, 0, 0, 1, 32'h0000_00A5, 1, 20'hABCDE, 0, 0, 0);
    step(1, 8'h11, 1, 1, 32'hFFFF_FFFF, 1, 20'h12345, 1, 8'hF0, 32'h0000_4000);
    check("R8 explicit code wins, base write dropped", trapVector, 32'hABCD_E110);
    check("R8 status write dropped", psrRdData, 32'h0400_00C4);
    check("R8 mask write dropped", 32'(wimRdData), 32'h1);
    // R6: trap with traps disabled
    step(1, 8'h05, 0, 0, 0, 0, 0, 0, 0, 32'h0000_5000);
    check("R6 error raised", 32'(errorState), 32'd1);
    check("R6 window frozen", 32'(cwpOut), 32'd4);
    check("R6 vector frozen", trapVector, 32'hABCD_E110);
    idle();
    check("R6 error sticky", 32'(errorState), 32'd1);
    // random phase
    for (int i = 0; i < 600; i++) begin
      logic [31:0] pd;
      pd = $urandom();
      if ($urandom_range(0, 2) != 0) pd[5] = 1'b1;
      step(($urandom_range(0, 7) == 0), 8'($urandom()), ($urandom_range(0, 3) == 0),
           ($urandom_range(0, 4) == 0), pd,
           ($urandom_range(0, 9) == 0), 20'($urandom()),
           ($urandom_range(0, 9) == 0), NW'($urandom()), $urandom());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule